// File: doc/BRIEF.md
# Redundant Reference Clock Failover Controller

This block chooses which of two reference clocks feeds a downstream PLL. A feedback clock from the PLL acts as the time base for health monitoring. Each reference is checked once per feedback period. A reference that made no transition during a whole feedback period is marked bad, and the mark is held until an explicit clear. All three clocks and the clear pin are sampled by a faster system clock and are handled in that domain.

The block has two modes. With manual override high, the reference is always the one named by the primary-select pin, and the health flags are still updated. With manual override low, the first reference to fail sets its flag and the selection moves to the other input. That choice is then frozen until a falling edge on the active-low alarm-reset pin clears every latch. After each change of selection, the block issues a one-cycle realignment strobe. The strobe follows the first falling edge of the newly chosen reference, so the PLL can realign on the next rising-edge pair of feedback and reference.

Top module: `refclk_failover`

## Requirements
- R1: `primSel` = 0 names clock 0 as primary and `primSel` = 1 names clock 1. `selIndicator` is 0 when clock 0 is the reference and 1 when clock 1 is. `refEn` bit i is high only when clock i is the reference.
- R2: When a reference stays high, or stays low, for a full feedback period (measured between rising edges of `fbClk`), its flag (`badFlag[0]` for clock 0, `badFlag[1]` for clock 1) goes high. This happens within three feedback periods of the input stopping. A reference that keeps toggling never sets its flag.
- R3: Once a flag is set, it stays set until an alarm clear, even if the reference starts toggling again.
- R4: Only a high-to-low transition of `alarmRstN` clears the latches. It produces a single-cycle clear that resets both flags and sets the selection to `primSel`. A low level held afterwards and a low-to-high transition have no effect.
- R5: While `manualOvr` = 1, the selection follows `primSel` every cycle, whatever the flags are. Flags are still set by dead inputs.
- R6: While `manualOvr` = 0, a failure on one input with no flag yet set moves the selection to the other input. While any flag is set, the selection holds until an alarm clear and never moves onto a flagged input.
- R7: While neither flag is set and no input has just failed, the selection follows `primSel` in both modes.
- R8: If both inputs are found dead in the same check with no flag set in automatic mode, both flags are set and clock 0 is selected. This includes both inputs being dead across an alarm clear.
- R9: Each change of selection is followed by exactly one single-cycle `realign` pulse. The pulse comes after the first falling edge of the newly selected reference, and no pulse appears before that edge.
- R10: Synchronous active-high `rst` clears both flags, loads the selection from `primSel`, and cancels a pending realignment strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| refClk0 | input | 1 | Reference clock 0 (asynchronous) |
| refClk1 | input | 1 | Reference clock 1 (asynchronous) |
| fbClk | input | 1 | PLL feedback clock (asynchronous) |
| primSel | input | 1 | Primary select, 0 = clock 0, 1 = clock 1 |
| manualOvr | input | 1 | 1 = manual selection, 0 = automatic failover |
| alarmRstN | input | 1 | Active-low alarm reset, acts on its falling edge |
| badFlag | output | 2 | Latched dead-input flags, bit i for clock i |
| selIndicator | output | 1 | Current reference, 0 = clock 0, 1 = clock 1 |
| refEn | output | 2 | One-hot enable of the current reference |
| realign | output | 1 | One-cycle strobe after the new reference's first falling edge |

## Verification
The hardest condition to reach is a realignment strobe that is pending and must be cancelled. This requires a switch of selection while the new reference makes no falling edge, and then a reset before it does. The bench reaches it by parking clock 1 high, switching to it manually, confirming that no strobe appears, resetting, and then restarting the clock to show the strobe stays cancelled. The second hard case is both inputs dead across an alarm clear. Both generators are stopped, the clear pin is given a falling edge, and the bench checks the brief return to `primSel` and then the two flags with clock 0 selected.

// File: rtl/refclk_failover_pkg.sv
package refclk_failover_pkg;

  localparam int NUM_REF = 2;

  typedef struct packed {
    logic                fbRise;
    logic [NUM_REF-1:0]  dead;
    logic [NUM_REF-1:0]  fall;
    logic                alarmClr;
  } dpEvents_t;

endpackage

// File: rtl/refclk_sync.sv
module refclk_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shr;

  always_ff @(posedge clk) begin
    if (rst) shr <= {STAGES{RESET_VAL}};
    else     shr <= {shr[STAGES-2:0], d};
  end

  assign q = shr[STAGES-1];
endmodule

// File: rtl/refclk_failover_dp.sv
module refclk_failover_dp
  import refclk_failover_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REF-1:0] refClk,
  input  logic               fbClk,
  input  logic               alarmRstN,
  output dpEvents_t          ev
);
  logic fbSync, fbPrev, fbRise;
  logic alSync, alPrev;
  logic armedQ;

  refclk_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uFbSync (
    .clk(clk), .rst(rst), .d(fbClk), .q(fbSync));
  refclk_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uAlSync (
    .clk(clk), .rst(rst), .d(alarmRstN), .q(alSync));

  always_ff @(posedge clk) begin
    if (rst) begin
      fbPrev <= 1'b0;
      alPrev <= 1'b1;
    end else begin
      fbPrev <= fbSync;
      alPrev <= alSync;
    end
  end

  assign fbRise = fbSync & ~fbPrev;
  assign ev.fbRise   = fbRise;
  assign ev.alarmClr = alPrev & ~alSync;

  // First feedback edge after reset or clear opens a full window.
  always_ff @(posedge clk) begin
    if (rst || ev.alarmClr) armedQ <= 1'b0;
    else if (fbRise)        armedQ <= 1'b1;
  end

  for (genvar i = 0; i < NUM_REF; i++) begin : gRef
    logic refSync, refPrev, refEdge, actQ;

    refclk_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uRefSync (
      .clk(clk), .rst(rst), .d(refClk[i]), .q(refSync));

    always_ff @(posedge clk) begin
      if (rst) refPrev <= 1'b0;
      else     refPrev <= refSync;
    end

    assign refEdge    = refSync ^ refPrev;
    assign ev.fall[i] = refPrev & ~refSync;
    assign ev.dead[i] = fbRise & armedQ & ~(actQ | refEdge);

    always_ff @(posedge clk) begin
      if (rst || ev.alarmClr) actQ <= 1'b0;
      else if (fbRise)        actQ <= 1'b0;
      else if (refEdge)       actQ <= 1'b1;
    end
  end

  assert_clr_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    ev.alarmClr |=> !ev.alarmClr);

  assert_dead_on_fb_R2: assert property (@(posedge clk) disable iff (rst)
    (ev.dead != '0) |-> $past(armedQ));
endmodule

// File: rtl/refclk_failover_ctl.sv
module refclk_failover_ctl
  import refclk_failover_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  dpEvents_t          ev,
  input  logic               primSel,
  input  logic               manualOvr,
  output logic [NUM_REF-1:0] badQ,
  output logic               selQ,
  output logic               realignQ
);
  logic [NUM_REF-1:0] badNext;
  logic               selNext;
  logic               switching;
  logic               pendingQ;

  always_comb begin
    badNext = badQ | ev.dead;
    selNext = selQ;
    if (ev.alarmClr) begin
      badNext = '0;
      selNext = primSel;
    end else if (manualOvr) begin
      selNext = primSel;
    end else if (badQ != '0) begin
      selNext = selQ;
    end else if (ev.dead == 2'b11) begin
      selNext = 1'b0;
    end else if (ev.dead[0]) begin
      selNext = 1'b1;
    end else if (ev.dead[1]) begin
      selNext = 1'b0;
    end else begin
      selNext = primSel;
    end
  end

  assign switching = (selNext != selQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      badQ     <= '0;
      selQ     <= primSel;
      pendingQ <= 1'b0;
      realignQ <= 1'b0;
    end else begin
      badQ     <= badNext;
      selQ     <= selNext;
      realignQ <= pendingQ & ev.fall[selQ] & ~switching;
      if (switching)                pendingQ <= 1'b1;
      else if (ev.fall[selQ])       pendingQ <= 1'b0;
    end
  end

  assert_flag0_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (badQ[0] && !ev.alarmClr) |=> badQ[0]);

  assert_flag1_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (badQ[1] && !ev.alarmClr) |=> badQ[1]);

  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    ev.alarmClr |=> (badQ == '0) && (selQ == $past(primSel)));

  assert_manual_follow_R5: assert property (@(posedge clk) disable iff (rst)
    manualOvr |=> (selQ == $past(primSel)));

  assert_sticky_sel_R6: assert property (@(posedge clk) disable iff (rst)
    (!manualOvr && (badQ != '0) && !ev.alarmClr) |=> $stable(selQ));

  assert_both_dead_R8: assert property (@(posedge clk) disable iff (rst)
    (!manualOvr && (badQ == '0) && (ev.dead == 2'b11) && !ev.alarmClr)
      |=> (!selQ && (badQ == 2'b11)));

  assert_strobe_pending_R9: assert property (@(posedge clk) disable iff (rst)
    realignQ |-> $past(pendingQ));

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
    realignQ |=> !realignQ);
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover
  import refclk_failover_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       refClk0,
  input  logic       refClk1,
  input  logic       fbClk,
  input  logic       primSel,
  input  logic       manualOvr,
  input  logic       alarmRstN,
  output logic [1:0] badFlag,
  output logic       selIndicator,
  output logic [1:0] refEn,
  output logic       realign
);
  dpEvents_t ev;
  logic      selQ;

  refclk_failover_dp #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rst(rst), .refClk({refClk1, refClk0}), .fbClk(fbClk),
    .alarmRstN(alarmRstN), .ev(ev));

  refclk_failover_ctl uCtl (
    .clk(clk), .rst(rst), .ev(ev), .primSel(primSel), .manualOvr(manualOvr),
    .badQ(badFlag), .selQ(selQ), .realignQ(realign));

  assign selIndicator = selQ;

  for (genvar i = 0; i < NUM_REF; i++) begin : gEn
    assign refEn[i] = (selQ == i[0]);
  end
endmodule

// File: tb/sim_refclk_failover.sv
module sim_refclk_failover;
  localparam int CLK_PERIOD = 10;
  localparam int REF0_HALF  = 40;
  localparam int REF1_HALF  = 50;
  localparam int FB_HALF    = 100;
  localparam int DEAD_WAIT  = 80;
  localparam int WATCHDOG   = 100000;

  logic clk = 0, rst = 1;
  logic refClk0 = 0, refClk1 = 0, fbClk = 0;
  logic primSel = 0, manualOvr = 0, alarmRstN = 1;
  logic run0 = 1, run1 = 1;
  logic [1:0] badFlag, refEn;
  logic selIndicator, realign;

  int errors = 0, checks = 0, strobes = 0;

  refclk_failover u0 (
    .clk(clk), .rst(rst), .refClk0(refClk0), .refClk1(refClk1), .fbClk(fbClk),
    .primSel(primSel), .manualOvr(manualOvr), .alarmRstN(alarmRstN),
    .badFlag(badFlag), .selIndicator(selIndicator), .refEn(refEn),
    .realign(realign));

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever begin #(REF0_HALF); if (run0) refClk0 = ~refClk0; end
  initial forever begin #(REF1_HALF); if (run1) refClk1 = ~refClk1; end
  initial forever begin #(FB_HALF); fbClk = ~fbClk; end

  always @(negedge clk) if (!rst && realign) strobes++;

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stopRef(input int idx, input logic lvl);
    if (idx == 0) begin run0 = 0; refClk0 = lvl; end
    else          begin run1 = 0; refClk1 = lvl; end
  endtask

  task automatic startRef(input int idx);
    if (idx == 0) run0 = 1; else run1 = 1;
  endtask

  task automatic alarmFall();
    alarmRstN = 1; waitCyc(5);
    alarmRstN = 0; waitCyc(8);
  endtask

  task automatic testReset();
    primSel = 0; manualOvr = 0;
    rst = 1; waitCyc(4); rst = 0; waitCyc(2);
    chk("R10 flags after reset", badFlag, 0);
    chk("R1 select clock 0", selIndicator, 0);
    chk("R1 enable clock 0", refEn, 2'b01);
  endtask

  task automatic testManual();
    int s0;
    manualOvr = 1; s0 = strobes;
    primSel = 1; waitCyc(2);
    chk("R5 manual follows 1", selIndicator, 1);
    chk("R1 enable clock 1", refEn, 2'b10);
    waitCyc(30);
    chk("R9 strobe after manual switch", strobes - s0, 1);
    primSel = 0; waitCyc(2);
    chk("R5 manual follows 0", selIndicator, 0);
    waitCyc(30);
  endtask

  task automatic testAutoFree();
    manualOvr = 0; primSel = 1; waitCyc(2);
    chk("R7 auto follows 1", selIndicator, 1);
    primSel = 0; waitCyc(2);
    chk("R7 auto follows 0", selIndicator, 0);
    waitCyc(DEAD_WAIT);
    chk("R2 toggling clocks not flagged", badFlag, 0);
  endtask

  task automatic testFailover();
    int s0;
    s0 = strobes;
    stopRef(0, 1'b0); waitCyc(DEAD_WAIT);
    chk("R2 clock 0 stuck low flagged", badFlag, 2'b01);
    chk("R6 failover to clock 1", selIndicator, 1);
    chk("R9 strobe after failover", strobes - s0, 1);
    startRef(0); primSel = 1; waitCyc(3); primSel = 0; waitCyc(DEAD_WAIT);
    chk("R3 flag held after recovery", badFlag, 2'b01);
    chk("R6 selection sticky", selIndicator, 1);
    stopRef(1, 1'b1); waitCyc(DEAD_WAIT);
    chk("R2 clock 1 stuck high flagged", badFlag, 2'b11);
    chk("R6 no move onto flagged input", selIndicator, 1);
    startRef(1);
  endtask

  task automatic testAlarm();
    primSel = 0; alarmFall();
    chk("R4 clear flags", badFlag, 0);
    chk("R4 clear selects primary", selIndicator, 0);
    stopRef(1, 1'b0); waitCyc(DEAD_WAIT);
    chk("R4 held low does not clear", badFlag, 2'b10);
    chk("R6 secondary fail keeps clock 0", selIndicator, 0);
    startRef(1); alarmRstN = 1; waitCyc(10);
    chk("R4 rising edge does not clear", badFlag, 2'b10);
    alarmRstN = 0; waitCyc(8);
    chk("R4 second fall clears", badFlag, 0);
    alarmRstN = 1; waitCyc(DEAD_WAIT);
  endtask

  task automatic testBothDead();
    primSel = 1; waitCyc(2);
    stopRef(0, 1'b1); stopRef(1, 1'b0);
    alarmFall();
    chk("R4 clear returns to primary 1", selIndicator, 1);
    chk("R4 flags clear at alarm", badFlag, 0);
    waitCyc(DEAD_WAIT);
    chk("R8 both flagged", badFlag, 2'b11);
    chk("R8 clock 0 selected", selIndicator, 0);
    startRef(0); startRef(1);
    alarmRstN = 1; waitCyc(5);
  endtask

  task automatic testManualFail();
    manualOvr = 1; primSel = 0;
    alarmFall(); alarmRstN = 1;
    stopRef(0, 1'b0); waitCyc(DEAD_WAIT);
    chk("R5 manual still flags", badFlag, 2'b01);
    chk("R5 manual keeps dead primary", selIndicator, 0);
    primSel = 1; waitCyc(2);
    chk("R5 manual follows despite flag", selIndicator, 1);
    startRef(0); waitCyc(30);
  endtask

  task automatic testCancel();
    int s0;
    manualOvr = 1; primSel = 0; waitCyc(30);
    stopRef(1, 1'b1); waitCyc(5);
    s0 = strobes;
    primSel = 1; waitCyc(30);
    chk("R9 no strobe before falling edge", strobes - s0, 0);
    rst = 1; waitCyc(1); rst = 0; waitCyc(1);
    chk("R10 reset loads primSel", selIndicator, 1);
    chk("R10 reset clears flags", badFlag, 0);
    startRef(1); waitCyc(40);
    chk("R10 pending strobe cancelled", strobes - s0, 0);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(WATCHDOG * CLK_PERIOD);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    testReset();
    testManual();
    testAutoFree();
    testFailover();
    testAlarm();
    testBothDead();
    testManualFail();
    testCancel();
    summary();
  end
endmodule